// File: doc/BRIEF.md
# Row Write Latch and Self-Timed Programming Sequencer

This block sits between a two-wire serial slave front end and a small nonvolatile byte array. The front end reports bus events to it: a START, a STOP, the received address byte (seven address bits plus a read/write flag), and each received data byte. The block gathers up to one row of data bytes in a latch, tells the front end whether a data byte may be acknowledged, and applies hardware write protection sampled during the addressing phase.

A STOP that closes a write transaction holding at least one latched byte launches a programming cycle of fixed length. During that cycle the latched bytes are copied into the array and the block reports busy. Every bus event is ignored until busy falls. The array is modelled here as a resettable register file with one write port and one asynchronous read port. Every location reads all ones after reset.

The address splits into a row part (upper bits) and a column part (the two low bits for a four-byte row). Only the column part advances after each accepted byte, and it wraps inside the row.

Top module: `rws_top`

## Requirements
- R1: After reset, every array location reads 0xFF, `busy` is 0 and `ack_ok` is 0.
- R2: An address byte with `rnw_in` = 0, taken while `wp_in` stayed low, makes `ack_ok` 1 until the next STOP or START. With `rnw_in` = 1, `ack_ok` stays 0 and data bytes change nothing.
- R3: If `wp_in` is 1 in the START cycle or in any cycle up to and including the address-byte cycle, `ack_ok` stays 0 and the array is unchanged. `wp_in` asserted only after the address byte has no effect on the write.
- R4: Data bytes go to the address whose upper five bits equal `addr_in[6:2]`. The column starts at `addr_in[1:0]` and advances by one modulo 4 after each byte.
- R5: When more than four bytes are sent, a later byte replaces the earlier byte that landed in the same column. The last one written to a column is the one programmed.
- R6: Only the columns loaded in the transaction are programmed. All other locations keep their contents.
- R7: A STOP after at least one accepted data byte raises `busy` on the clock edge that samples the STOP. `busy` stays high for exactly PROG_CYCLES cycles, and by the time it falls the array holds the new bytes.
- R8: No programming occurs without a STOP. A START before the STOP discards the latched bytes, and a STOP with no data bytes leaves `busy` at 0.
- R9: While `busy` is high, `ack_ok` is 0, and START, STOP, address and data strobes and `wp_in` have no effect on the array or on the length of the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | One-cycle strobe: START seen on the bus |
| bus_stop | input | 1 | One-cycle strobe: STOP seen on the bus |
| addr_valid | input | 1 | One-cycle strobe: address byte received |
| addr_in | input | ADDR_W | Address carried by the address byte |
| rnw_in | input | 1 | Read (1) or write (0) flag of the address byte |
| wp_in | input | 1 | Hardware write protect, active high |
| byte_valid | input | 1 | One-cycle strobe: data byte received |
| byte_data | input | DATA_W | Received data byte |
| rd_addr | input | ADDR_W | Array read address |
| ack_ok | output | 1 | Data bytes of this transaction may be acknowledged |
| busy | output | 1 | Programming cycle in progress |
| rd_data | output | DATA_W | Array read data |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The bench builds the block with its default geometry: a 7-bit address, 8-bit data and four-byte rows, so the whole 128-location array is compared with a bench model after every transaction. PROG_CYCLES is set to 12. That is long enough that the four column slots and several idle cycles fall inside each busy window, and short enough for dozens of programming cycles to run. Within that window the bench can exactly count the busy length and inject stray bus events into it. Column wrap, overwrite past the fourth byte and partial rows are reached both by directed cases and by random start columns with lengths of zero to six bytes.

// File: rtl/rws_pkg.sv
package rws_pkg;

    localparam int DEF_ADDR_W      = 7;
    localparam int DEF_DATA_W      = 8;
    localparam int DEF_ROW_BYTES   = 4;
    localparam int DEF_PROG_CYCLES = 1000;

    typedef enum logic [2:0] {
        TX_IDLE  = 3'd0,
        TX_ADDR  = 3'd1,
        TX_WRITE = 3'd2,
        TX_SKIP  = 3'd3,
        TX_PROG  = 3'd4
    } tx_state_e;

    // Protection holds if the pin was seen high at any point of addressing.
    function automatic logic wp_latch(input logic held, input logic pin);
        return held | pin;
    endfunction

    // A write transaction may proceed only for a write flag without protection.
    function automatic tx_state_e addr_outcome(input logic rnw, input logic prot);
        return (rnw || prot) ? TX_SKIP : TX_WRITE;
    endfunction

endpackage

// File: rtl/rws_row_latch.sv
module rws_row_latch #(
    parameter int DATA_W    = rws_pkg::DEF_DATA_W,
    parameter int ROW_BYTES = rws_pkg::DEF_ROW_BYTES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic                        load,
    input  logic [$clog2(ROW_BYTES)-1:0] load_col,
    input  logic                        push,
    input  logic [DATA_W-1:0]           push_data,
    output logic [ROW_BYTES*DATA_W-1:0] row_data,
    output logic [ROW_BYTES-1:0]        row_vld
);
    localparam int COL_W = $clog2(ROW_BYTES);

    logic [COL_W-1:0] ptr_q;

    // Column pointer: loaded from the address byte, wraps inside the row.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_col;
        end else if (push) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    for (genvar s = 0; s < ROW_BYTES; s++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        logic              vld_q;
        logic              hit;

        assign hit = push && (ptr_q == COL_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
                vld_q  <= 1'b0;
            end else if (clear) begin
                vld_q  <= 1'b0;
            end else if (hit) begin
                slot_q <= push_data;
                vld_q  <= 1'b1;
            end
        end

        assign row_data[s*DATA_W +: DATA_W] = slot_q;
        assign row_vld[s]                   = vld_q;
    end

endmodule

// File: rtl/rws_prog_seq.sv
module rws_prog_seq #(
    parameter int ADDR_W      = rws_pkg::DEF_ADDR_W,
    parameter int DATA_W      = rws_pkg::DEF_DATA_W,
    parameter int ROW_BYTES   = rws_pkg::DEF_ROW_BYTES,
    parameter int PROG_CYCLES = rws_pkg::DEF_PROG_CYCLES
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         launch,
    input  logic [ADDR_W-$clog2(ROW_BYTES)-1:0]          row_base,
    input  logic [ROW_BYTES*DATA_W-1:0]                  row_data,
    input  logic [ROW_BYTES-1:0]                         row_vld,
    output logic                                         busy,
    output logic                                         done,
    output logic                                         we,
    output logic [ADDR_W-1:0]                            waddr,
    output logic [DATA_W-1:0]                            wdata
);
    localparam int COL_W = $clog2(ROW_BYTES);
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int CNT_W = $clog2(PROG_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] SLOTS = CNT_W'(ROW_BYTES);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [ROW_W-1:0] base_q;
    logic [COL_W-1:0] slot;
    logic             in_window;

    // Busy window of fixed length; the first ROW_BYTES cycles issue writes.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            base_q <= '0;
        end else if (!busy_q) begin
            if (launch) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                base_q <= row_base;
            end
        end else if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign slot      = cnt_q[COL_W-1:0];
    assign in_window = busy_q && (cnt_q < SLOTS);
    assign busy      = busy_q;
    assign done      = busy_q && (cnt_q == LAST);
    assign we        = in_window && row_vld[slot];
    assign waddr     = {base_q, slot};
    assign wdata     = row_data[slot*DATA_W +: DATA_W];

endmodule

// File: rtl/rws_cell_array.sv
module rws_cell_array #(
    parameter int ADDR_W = rws_pkg::DEF_ADDR_W,
    parameter int DATA_W = rws_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Erased state is all ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rws_top.sv
module rws_top #(
    parameter int ADDR_W      = rws_pkg::DEF_ADDR_W,
    parameter int DATA_W      = rws_pkg::DEF_DATA_W,
    parameter int ROW_BYTES   = rws_pkg::DEF_ROW_BYTES,
    parameter int PROG_CYCLES = rws_pkg::DEF_PROG_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              rnw_in,
    input  logic              wp_in,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              ack_ok,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    import rws_pkg::*;

    localparam int COL_W = $clog2(ROW_BYTES);
    localparam int ROW_W = ADDR_W - COL_W;

    tx_state_e                  state_q, state_d;
    logic                       wp_hold_q, wp_hold_d;
    logic [ROW_W-1:0]           base_q, base_d;
    logic                       launch, clear, load, push;
    logic [ROW_BYTES*DATA_W-1:0] row_data;
    logic [ROW_BYTES-1:0]       row_vld;
    logic                       seq_done;

    always_comb begin
        state_d   = state_q;
        wp_hold_d = wp_hold_q;
        base_d    = base_q;
        launch    = 1'b0;
        clear     = 1'b0;
        load      = 1'b0;
        push      = 1'b0;
        if (state_q == TX_PROG) begin
            // Bus is deaf while the cycle runs.
            if (seq_done) begin
                state_d = TX_IDLE;
                clear   = 1'b1;
            end
        end else if (bus_start) begin
            state_d   = TX_ADDR;
            wp_hold_d = wp_in;
            clear     = 1'b1;
        end else if (bus_stop) begin
            if (state_q == TX_WRITE && (|row_vld)) begin
                state_d = TX_PROG;
                launch  = 1'b1;
            end else begin
                state_d = TX_IDLE;
                clear   = 1'b1;
            end
        end else begin
            case (state_q)
                TX_ADDR: begin
                    wp_hold_d = wp_latch(wp_hold_q, wp_in);
                    if (addr_valid) begin
                        base_d  = addr_in[ADDR_W-1:COL_W];
                        load    = 1'b1;
                        state_d = addr_outcome(rnw_in, wp_latch(wp_hold_q, wp_in));
                    end
                end
                TX_WRITE: push = byte_valid;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= TX_IDLE;
            wp_hold_q <= 1'b0;
            base_q    <= '0;
        end else begin
            state_q   <= state_d;
            wp_hold_q <= wp_hold_d;
            base_q    <= base_d;
        end
    end

    rws_row_latch #(
        .DATA_W   (DATA_W),
        .ROW_BYTES(ROW_BYTES)
    ) u_latch (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .load     (load),
        .load_col (addr_in[COL_W-1:0]),
        .push     (push),
        .push_data(byte_data),
        .row_data (row_data),
        .row_vld  (row_vld)
    );

    rws_prog_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .ROW_BYTES  (ROW_BYTES),
        .PROG_CYCLES(PROG_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .row_base(base_q),
        .row_data(row_data),
        .row_vld (row_vld),
        .busy    (busy),
        .done    (seq_done),
        .we      (arr_we),
        .waddr   (arr_addr),
        .wdata   (arr_wdata)
    );

    rws_cell_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk  (clk),
        .rst  (rst),
        .we   (arr_we),
        .waddr(arr_addr),
        .wdata(arr_wdata),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    assign ack_ok = (state_q == TX_WRITE);

endmodule

// File: rtl/rws_checker.sv
module rws_checker #(
    parameter int ROW_W       = 5,
    parameter int PROG_CYCLES = rws_pkg::DEF_PROG_CYCLES
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_stop,
    input logic             ack_ok,
    input logic             busy,
    input logic             arr_we,
    input logic [ROW_W-1:0] arr_row
);
    localparam int RUN_W = $clog2(PROG_CYCLES + 1);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !ack_ok));

    assert_busy_length_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_q == RUN_W'(PROG_CYCLES)));

    assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < RUN_W'(PROG_CYCLES)));

    assert_busy_from_stop_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_stop));

    assert_write_only_busy_R8: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    assert_no_ack_busy_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ack_ok);

    assert_single_row_R4: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> (arr_row == $past(arr_row)));

endmodule

bind rws_top rws_checker #(
    .ROW_W      (ROW_W),
    .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_stop(bus_stop),
    .ack_ok  (ack_ok),
    .busy    (busy),
    .arr_we  (arr_we),
    .arr_row (arr_addr[ADDR_W-1:COL_W])
);

// File: tb/rws_top_test.sv
module rws_top_test;
    localparam int PROG = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_start = 0, bus_stop = 0, addr_valid = 0, rnw_in = 0;
    logic       wp_in = 0, byte_valid = 0;
    logic [6:0] addr_in = '0, rd_addr = '0;
    logic [7:0] byte_data = '0;
    logic       ack_ok, busy, arr_we;
    logic [7:0] rd_data, arr_wdata;
    logic [6:0] arr_addr;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_mem [128];

    always #5 clk = ~clk;

    rws_top #(.ADDR_W(7), .DATA_W(8), .ROW_BYTES(4), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_valid(addr_valid), .addr_in(addr_in), .rnw_in(rnw_in), .wp_in(wp_in),
        .byte_valid(byte_valid), .byte_data(byte_data), .rd_addr(rd_addr),
        .ack_ok(ack_ok), .busy(busy), .rd_data(rd_data), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_mem(input string req);
        int bad = -1;
        logic [7:0] got = '0;
        for (int i = 0; i < 128; i++) begin
            rd_addr = 7'(i);
            #1;
            if (bad < 0 && rd_data !== exp_mem[i]) begin
                bad = i;
                got = rd_data;
            end
        end
        chk(bad < 0, req, (bad < 0) ? 0 : {bad, 8'h00} | got,
            (bad < 0) ? 0 : {bad, 8'h00} | exp_mem[bad]);
    endtask

    // One transaction; wps: WC in START cycle, wpa: WC in addressing cycle,
    // wpl: WC after the address byte, abort: START instead of STOP, junk: stray events in busy.
    task automatic txn(input logic [6:0] a, input int nb, input bit rnw, input bit wps,
                       input bit wpa, input bit wpl, input bit abort, input bit junk,
                       input string req);
        logic [7:0] bufd [4];
        bit         bv [4];
        logic [1:0] col = a[1:0];
        bit writable = !rnw && !wps && !wpa;
        bit prog;
        int n = 0;
        for (int k = 0; k < 4; k++) bv[k] = 0;
        @(negedge clk) bus_start = 1; wp_in = wps;
        @(negedge clk) bus_start = 0; wp_in = wpa;
        @(negedge clk) wp_in = 0; addr_valid = 1; addr_in = a; rnw_in = rnw;
        @(negedge clk) addr_valid = 0; wp_in = wpl;
        chk(ack_ok == writable, writable ? "R2" : (rnw ? "R2" : "R3"), ack_ok, writable);
        for (int i = 0; i < nb; i++) begin
            logic [7:0] d = 8'($urandom);
            byte_valid = 1; byte_data = d;
            if (writable) begin
                bufd[col] = d; bv[col] = 1; col = col + 2'd1;
            end
            @(negedge clk) byte_valid = 0;
            @(negedge clk);
        end
        wp_in = 0;
        prog = writable && nb > 0 && !abort;
        if (abort) begin
            bus_start = 1;
            @(negedge clk) bus_start = 0;
            @(negedge clk) bus_stop = 1;
            @(negedge clk) bus_stop = 0;
            chk(busy == 0, "R8", busy, 0);
        end else begin
            bus_stop = 1;
            @(negedge clk) bus_stop = 0;
            chk(busy == prog, prog ? "R7" : "R8", busy, prog);
            if (prog) begin
                while (busy && n < PROG + 10) begin
                    n++;
                    if (junk && n == 2) begin
                        bus_start = 1; bus_stop = 1; addr_valid = 1; byte_valid = 1;
                        wp_in = 1; addr_in = 7'h00; byte_data = 8'h5A;
                    end
                    @(negedge clk);
                    if (junk && n == 2) chk(ack_ok == 0, "R9", ack_ok, 0);
                    bus_start = 0; bus_stop = 0; addr_valid = 0; byte_valid = 0; wp_in = 0;
                end
                chk(n == PROG, junk ? "R9" : "R7", n, PROG);
            end else begin
                @(negedge clk);
                chk(busy == 0, "R8", busy, 0);
            end
        end
        if (prog) begin
            for (int k = 0; k < 4; k++)
                if (bv[k]) exp_mem[{a[6:2], 2'(k)}] = bufd[k];
        end
        check_mem(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 128; i++) exp_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0, "R1", busy, 0);
        chk(ack_ok == 0, "R1", ack_ok, 0);
        check_mem("R1");

        txn(7'h25, 1, 0, 0, 0, 0, 0, 0, "R6");   // single byte
        txn(7'h40, 4, 0, 0, 0, 0, 0, 0, "R4");   // full row
        txn(7'h1A, 3, 0, 0, 0, 0, 0, 0, "R4");   // column wrap 2,3,0
        txn(7'h11, 6, 0, 0, 0, 0, 0, 0, "R5");   // overwrite past fourth byte
        txn(7'h60, 2, 0, 1, 0, 0, 0, 0, "R3");   // protect at START
        txn(7'h64, 2, 0, 0, 1, 0, 0, 0, "R3");   // protect during addressing
        txn(7'h68, 2, 0, 0, 0, 1, 0, 0, "R3");   // late protect ignored
        txn(7'h40, 3, 1, 0, 0, 0, 0, 0, "R2");   // read transaction
        txn(7'h30, 0, 0, 0, 0, 0, 0, 0, "R8");   // empty write
        txn(7'h30, 2, 0, 0, 0, 0, 1, 0, "R8");   // aborted by START
        txn(7'h0C, 2, 0, 0, 0, 0, 0, 1, "R9");   // stray events in busy
        txn(7'h7F, 2, 0, 0, 0, 0, 0, 0, "R4");   // top row wrap

        for (int t = 0; t < 40; t++) begin
            logic [6:0] a = 7'($urandom);
            int nb = int'($urandom % 7);
            bit rnw = ($urandom % 8) == 0;
            bit wps = ($urandom % 10) == 0;
            bit wpa = ($urandom % 10) == 0;
            bit wpl = ($urandom % 4) == 0;
            bit ab  = ($urandom % 10) == 0;
            bit jk  = ($urandom % 5) == 0;
            txn(a, nb, rnw, wps, wpa, wpl, ab, jk, "R6");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule